// File: doc/BRIEF.md
# Parallel Converter Conversion Sequencer

This block is the digital control section of a successive-approximation analog-to-digital converter with a byte-wide parallel bus interface. A host starts a conversion by pulling chip select and write low together. Once that pair is released, conversion time is measured by a single marker bit that walks through a timing shift register. When the marker leaves the last stage, the block copies the conversion result into its output register and raises a pending-result interrupt. The interrupt pin is active low.

The host collects the result with chip select and read both low. That read drives the stored byte onto a tri-stated data bus and clears the interrupt. The successive-approximation result comes from an external register, `sar_value`, which a stand-in model supplies. All three strobes pass through a synchroniser before any logic uses them. In all timings below, "edge n" means the n-th rising clock edge after a strobe change was applied.

Top module: `pconv_ctrl`

## Requirements
- R1: While reset is held and right after it, `intr_n` is 1 and `data_oe` is 0.
- R2: A conversion starts only when `cs_n` and `wr_n` are both low. `wr_n` low with `cs_n` high starts nothing, so `intr_n` stays 1.
- R3: While `cs_n` and `wr_n` stay low together, no conversion completes, however long the pair is held. `intr_n` stays 1.
- R4: With the default parameters (2 synchroniser stages, 8 timing stages), `intr_n` reads 1 after edge 12 following the release of the start pair and reads 0 after edge 13.
- R5: The byte stored is the `sar_value` present in the cycle before edge 12 after release, which is when the marker reaches the last timing stage.
  - A value applied earlier in the conversion is replaced by that one.
  - A value applied after edge 12 does not change the stored byte.
- R6: `intr_n` is 0 exactly while an unread result is pending.
- R7: With `cs_n` and `rd_n` both low, `data_oe` is 1 from edge 2 onward and `data_bus` carries the stored byte. `intr_n` returns to 1 after edge 3.
- R8: `rd_n` low with `cs_n` high leaves `data_oe` at 0 and leaves a pending `intr_n` at 0.
- R9: A new start while a result is pending clears `intr_n` to 1 by edge 4 after the start pair goes low. The new result then overwrites the stored byte.
- R10: Each start yields exactly one completion. Once a result has been read, `intr_n` stays 1 until the next start, and the timing register never holds more than one marker bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; with `cs_n` it starts a conversion |
| rd_n | input | 1 | Read strobe, active low; with `cs_n` it reads the result |
| sar_value | input | DATA_W | Result from the successive-approximation register |
| data_bus | output | DATA_W | Stored result; high impedance when not read |
| data_oe | output | 1 | High while `data_bus` is driven |
| intr_n | output | 1 | Result pending, active low |

## Verification
A lost or doubled marker in the timing register shows as an `intr_n` fall on the wrong edge, or as a second fall after a read, and it appears within the nine-cycle conversion window. A result register loaded on the wrong cycle shows on the next read as a byte from a superseded or late `sar_value`. A start flip-flop that fails to hold or to release shows either as a conversion that completes while the start pair is still low, or as an `intr_n` that never falls. The bench counts edges from each strobe change, so a one-cycle slip anywhere in the synchroniser or latch pipeline breaks the 12/13-edge boundary.

// File: rtl/pconv_pkg.sv
package pconv_pkg;

    // Synchronised strobe set; every field is active low.
    typedef struct packed {
        logic cs;
        logic wr;
        logic rd;
    } strobe_t;

    localparam int NUM_STROBES = $bits(strobe_t);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARMED,
        PH_TIMING,
        PH_PENDING
    } phase_e;

    function automatic logic pair_low(input logic a_n, input logic b_n);
        return (!a_n) && (!b_n);
    endfunction

    function automatic logic fell(input logic prev, input logic cur);
        return prev && !cur;
    endfunction

endpackage

// File: rtl/pconv_sync.sv
module pconv_sync
    import pconv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t raw,
    output strobe_t synced
);
    localparam int W = NUM_STROBES;

    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[g] <= '1;
                end else if (g == 0) begin
                    pipe[g] <= raw;
                end else begin
                    pipe[g] <= pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign synced = strobe_t'(pipe[STAGES-1]);

endmodule

// File: rtl/pconv_start.sv
module pconv_start
    import pconv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strb,
    output logic    start_q,
    output logic    arm_q,
    output logic    read_act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            start_q <= pair_low(strb.cs, strb.wr);
            // Input stage is set while start holds, and it is consumed on the first shift after release.
            arm_q   <= start_q;
        end
    end

    assign read_act = pair_low(strb.cs, strb.rd);

endmodule

// File: rtl/pconv_timer.sv
module pconv_timer #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           din,
    output logic [LEN-1:0] sr,
    output logic           done
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr <= '0;
        end else begin
            sr <= {sr[LEN-2:0], din};
        end
    end

    assign done = sr[LEN-1];

endmodule

// File: rtl/pconv_result.sv
module pconv_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_q,
    input  logic              done,
    input  logic [DATA_W-1:0] sar_value,
    input  logic              read_act,
    output logic [DATA_W-1:0] latched,
    output logic              intr_q
);
    import pconv_pkg::*;

    logic stage_q;
    logic stage_prev;
    logic set_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= '0;
        end else if (done) begin
            latched <= sar_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_q) begin
            stage_q    <= 1'b1;
            stage_prev <= 1'b1;
        end else begin
            stage_q    <= !done;
            stage_prev <= stage_q;
        end
    end

    assign set_pulse = fell(stage_prev, stage_q);

    always_ff @(posedge clk) begin
        if (rst || start_q) begin
            intr_q <= 1'b0;
        end else if (set_pulse) begin
            intr_q <= 1'b1;
        end else if (read_act) begin
            intr_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pconv_ctrl.sv
module pconv_ctrl
    import pconv_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TIMING_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] sar_value,
    output logic [DATA_W-1:0] data_bus,
    output logic              data_oe,
    output logic              intr_n
);
    strobe_t             raw_s;
    strobe_t             sync_s;
    logic                start_q;
    logic                arm_q;
    logic                read_act;
    logic [TIMING_LEN-1:0] timer_sr;
    logic                timer_done;
    logic [DATA_W-1:0]   latched;
    logic                intr_q;
    phase_e              phase;

    assign raw_s = '{cs: cs_n, wr: wr_n, rd: rd_n};

    pconv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_s), .synced(sync_s)
    );

    pconv_start u_start (
        .clk(clk), .rst(rst), .strb(sync_s),
        .start_q(start_q), .arm_q(arm_q), .read_act(read_act)
    );

    pconv_timer #(.LEN(TIMING_LEN)) u_timer (
        .clk(clk), .rst(rst), .clr(start_q), .din(arm_q),
        .sr(timer_sr), .done(timer_done)
    );

    pconv_result #(.DATA_W(DATA_W)) u_result (
        .clk(clk), .rst(rst), .start_q(start_q), .done(timer_done),
        .sar_value(sar_value), .read_act(read_act),
        .latched(latched), .intr_q(intr_q)
    );

    always_comb begin
        if (start_q)            phase = PH_ARMED;
        else if (|timer_sr)     phase = PH_TIMING;
        else if (intr_q)        phase = PH_PENDING;
        else                    phase = PH_IDLE;
    end

    assign data_oe  = read_act;
    assign data_bus = read_act ? latched : {DATA_W{1'bz}};
    assign intr_n   = !intr_q;

endmodule

// File: rtl/pconv_ctrl_chk.sv
module pconv_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int LEN    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_q,
    input logic [LEN-1:0]    timer_sr,
    input logic              timer_done,
    input logic [DATA_W-1:0] latched,
    input logic              data_oe,
    input logic              intr_n
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (intr_n && !data_oe)); // R1

    AST_HOLD_CLEARS_TIMER: assert property (@(posedge clk) disable iff (rst)
        start_q |=> (timer_sr == '0)); // R3

    AST_START_CLEARS_INTR: assert property (@(posedge clk) disable iff (rst)
        start_q |=> intr_n); // R9

    AST_INTR_AFTER_MARKER: assert property (@(posedge clk) disable iff (rst)
        $fell(intr_n) |-> $past(timer_done, 2)); // R4

    AST_LATCH_ON_MARKER: assert property (@(posedge clk) disable iff (rst)
        !$stable(latched) |-> $past(timer_done)); // R5

    AST_INTR_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(intr_n) |-> ($past(start_q) || $past(data_oe))); // R7

    AST_SINGLE_MARKER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(timer_sr)); // R10

endmodule

bind pconv_ctrl pconv_ctrl_chk #(.DATA_W(DATA_W), .LEN(TIMING_LEN)) u_chk (
    .clk(clk), .rst(rst), .start_q(start_q), .timer_sr(timer_sr),
    .timer_done(timer_done), .latched(latched), .data_oe(data_oe),
    .intr_n(intr_n)
);

// File: tb/pconv_ctrl_bench.sv
module pconv_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [7:0] sar_value = 8'h00;
    logic [7:0] data_bus;
    logic       data_oe;
    logic       intr_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pconv_ctrl u_pconv_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .sar_value(sar_value), .data_bus(data_bus), .data_oe(data_oe),
        .intr_n(intr_n)
    );

    // {sar stimulus, hold ticks, expected byte}
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 8'd1, 8'h00},
        {8'hFF, 8'd4, 8'hFF},
        {8'hA5, 8'd2, 8'hA5},
        {8'h7A, 8'd6, 8'h7A},
        {8'h01, 8'd3, 8'h01},
        {8'h80, 8'd1, 8'h80}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_conv(input int hold);
        cs_n = 1'b0; wr_n = 1'b0;
        tick(hold);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    // Read; checks bus and interrupt timing from the strobe drive.
    task automatic do_read(input logic [7:0] exp, input string req);
        cs_n = 1'b0; rd_n = 1'b0;
        tick(2);
        check(data_oe === 1'b1, req, data_oe, 1);
        check(data_bus === exp, req, data_bus, exp);
        tick(1);
        check(intr_n === 1'b1, req, intr_n, 1);
        cs_n = 1'b1; rd_n = 1'b1;
        tick(3);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(1);
        check(intr_n === 1'b1, "R1", intr_n, 1);
        check(data_oe === 1'b0, "R1", data_oe, 0);
        tick(3);
        rst = 1'b0;
        tick(2);
        check(intr_n === 1'b1 && data_oe === 1'b0, "R1", {intr_n, data_oe}, 2);

        // Table walk: conversion timing (R4, R6) then read (R7).
        for (int i = 0; i < 6; i++) begin
            sar_value = VEC[i][23:16];
            start_conv(int'(VEC[i][15:8]));
            tick(12);
            check(intr_n === 1'b1, "R4", intr_n, 1);
            tick(1);
            check(intr_n === 1'b0, "R4", intr_n, 0);
            tick(5);
            check(intr_n === 1'b0, "R6", intr_n, 0);
            do_read(VEC[i][7:0], "R7");
        end

        // R2: write without chip select starts nothing.
        sar_value = 8'h3C;
        wr_n = 1'b0; tick(4); wr_n = 1'b1;
        tick(20);
        check(intr_n === 1'b1, "R2", intr_n, 1);

        // R3: long hold never completes.
        sar_value = 8'h5A;
        cs_n = 1'b0; wr_n = 1'b0;
        tick(40);
        check(intr_n === 1'b1, "R3", intr_n, 1);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(13);
        check(intr_n === 1'b0, "R3", intr_n, 0);

        // R8: read strobe without chip select.
        rd_n = 1'b0; tick(4);
        check(data_oe === 1'b0, "R8", data_oe, 0);
        check(intr_n === 1'b0, "R8", intr_n, 0);
        rd_n = 1'b1; tick(1);

        // R9: new start while pending clears the interrupt and overwrites.
        sar_value = 8'hC3;
        cs_n = 1'b0; wr_n = 1'b0;
        tick(4);
        check(intr_n === 1'b1, "R9", intr_n, 1);
        cs_n = 1'b1; wr_n = 1'b1;
        tick(13);
        check(intr_n === 1'b0, "R9", intr_n, 0);
        do_read(8'hC3, "R9");

        // R5: mid-conversion change is superseded; late change ignored.
        sar_value = 8'h11;
        start_conv(4);
        tick(5);
        sar_value = 8'h96;
        tick(7);
        sar_value = 8'h2B;
        tick(1);
        check(intr_n === 1'b0, "R5", intr_n, 0);
        do_read(8'h96, "R5");

        // R10: no second completion after a read; byte still readable.
        tick(30);
        check(intr_n === 1'b1, "R10", intr_n, 1);
        do_read(8'h96, "R10");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule